// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 level-sensitive interrupt lines and presents them to a processor as two request outputs. One is a normal request and the other is a fast request. Each line can be enabled, steered to either output, or asserted from software. A table of sixteen prioritised vector slots maps chosen sources to handler addresses. The processor reads the handler address for the most urgent request from a single register.

Software programs the block over an APB-style register bus. A read of the current-vector register returns a handler address and opens a service level for that slot. That level masks the slot itself and every slot of lower priority, so only more urgent slots can preempt the handler. A write to the same register closes the most recent level, so nested handlers unwind in reverse order. A protection bit can limit register access to privileged bus transfers. A read-only identification word is provided as four byte-wide registers.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the enable, route, software and protection registers are all zero, no service level is open, and `irq_o` and `fiq_o` are low.
- R2: A write to 0x10 sets every enable bit where the data is 1. A write to 0x14 clears every enable bit where the data is 1. Zero data bits change nothing. A read of 0x10 returns the enable mask.
- R3: A write to 0x18 sets software request bits and a write to 0x1C clears them, both with write-one semantics. A read of 0x18 returns the mask. An enabled software bit raises its output exactly as a hardware line does.
- R4: Route register 0x0C: bit value 1 steers the source to `fiq_o`, and 0 steers it to `irq_o`. Offset 0x00 reads (line OR software) AND enable AND NOT route. Offset 0x04 reads the same with the route bit instead of its inverse.
- R5: `src_i` is sampled by one register, so a change driven between clock edges reaches the status and outputs only after the next rising edge.
- R6: Slot n has its handler address at 0x100+4n and its control word at 0x200+4n. Control bit 5 enables the slot and bits 4:0 hold its source number. Reading 0x30 returns the address of the lowest-numbered enabled slot whose source is pending on the normal path. If no slot qualifies, it returns the default address held at 0x34.
- R7: A read of 0x30 that returns a slot address opens a level for that slot. While the level is open, that slot and all higher-numbered slots are skipped, and lower-numbered slots can still be returned.
- R8: Any write to 0x30 closes the most recently opened (lowest-numbered) open level. With no level open it has no effect. Repeated read/write pairs unwind all nesting.
- R9: When bit 0 of 0x20 is 1, writes with `pprot_priv` low are ignored and reads with `pprot_priv` low return zero. Privileged accesses are not affected.
- R10: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC return bytes 0 to 3 of parameter `ID_CODE` in bits 7:0. The vendor code in bits 19:12 is 0x4A by default.
- R11: A write of zero to the test control register at 0x300 leaves all enable, route and software state unchanged.
- R12: A slot with control bit 5 clear is never returned. A source routed to the fast output never selects a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| pprot_priv | input | 1 | Privileged transfer when 1 |
| prdata | output | 32 | Read data, valid in the access phase |
| src_i | input | 32 | Interrupt lines, level-sensitive |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the two ways a request bit can be set. The bench holds a hardware line high and then sets and clears the software bit of the same source. It checks that the status bit survives the software clear.

The second pair is opening a service level and the arrival of a more urgent slot. The bench opens a level for a low-priority slot and then raises a higher-priority source. The scoreboard checks that the next vector read preempts to the new slot, that a further read falls back to the default address, and that write-backs unwind the levels in order.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // Register offsets (byte addresses)
  localparam logic [11:0] OFS_IRQ_STAT = 12'h000;
  localparam logic [11:0] OFS_FIQ_STAT = 12'h004;
  localparam logic [11:0] OFS_ROUTE    = 12'h00C;
  localparam logic [11:0] OFS_EN_SET   = 12'h010;
  localparam logic [11:0] OFS_EN_CLR   = 12'h014;
  localparam logic [11:0] OFS_SW_SET   = 12'h018;
  localparam logic [11:0] OFS_SW_CLR   = 12'h01C;
  localparam logic [11:0] OFS_PROT     = 12'h020;
  localparam logic [11:0] OFS_CUR_VEC  = 12'h030;
  localparam logic [11:0] OFS_DEF_VEC  = 12'h034;
  localparam logic [11:0] OFS_TESTCTL  = 12'h300;
  localparam logic [3:0]  PAGE_VADDR   = 4'h1;
  localparam logic [3:0]  PAGE_VCTL    = 4'h2;
  localparam logic [7:0]  PAGE_ID      = 8'hFE;
  localparam int          CTL_EN_BIT   = 5;

  typedef enum logic [3:0] {
    RS_NONE,
    RS_IRQ_STAT,
    RS_FIQ_STAT,
    RS_ROUTE,
    RS_EN_SET,
    RS_EN_CLR,
    RS_SW_SET,
    RS_SW_CLR,
    RS_PROT,
    RS_CUR_VEC,
    RS_DEF_VEC,
    RS_TESTCTL,
    RS_VADDR,
    RS_VCTL,
    RS_ID
  } reg_sel_e;
endpackage

// File: rtl/vic_bus_dec.sv
module vic_bus_dec
  import vic_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int SLW   = $clog2(NSLOT)
) (
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [11:0]     paddr,
  input  logic            pprot_priv,
  input  logic            prot_q,
  output logic            wr_ok,
  output logic            rd_ok,
  output reg_sel_e        rsel,
  output logic [SLW-1:0]  slot_idx,
  output logic [1:0]      id_idx
);
  logic allow;
  assign allow    = !prot_q || pprot_priv;
  assign wr_ok    = psel && penable && pwrite && allow;
  assign rd_ok    = psel && penable && !pwrite && allow;
  assign slot_idx = paddr[2 +: SLW];
  assign id_idx   = paddr[3:2];

  always_comb begin
    rsel = RS_NONE;
    if (paddr[1:0] == 2'b00) begin
      unique case (paddr)
        OFS_IRQ_STAT: rsel = RS_IRQ_STAT;
        OFS_FIQ_STAT: rsel = RS_FIQ_STAT;
        OFS_ROUTE:    rsel = RS_ROUTE;
        OFS_EN_SET:   rsel = RS_EN_SET;
        OFS_EN_CLR:   rsel = RS_EN_CLR;
        OFS_SW_SET:   rsel = RS_SW_SET;
        OFS_SW_CLR:   rsel = RS_SW_CLR;
        OFS_PROT:     rsel = RS_PROT;
        OFS_CUR_VEC:  rsel = RS_CUR_VEC;
        OFS_DEF_VEC:  rsel = RS_DEF_VEC;
        OFS_TESTCTL:  rsel = RS_TESTCTL;
        default: begin
          if (paddr[11:8] == PAGE_VADDR && paddr[7:2] < 6'(NSLOT))
            rsel = RS_VADDR;
          else if (paddr[11:8] == PAGE_VCTL && paddr[7:2] < 6'(NSLOT))
            rsel = RS_VCTL;
          else if (paddr[11:4] == PAGE_ID)
            rsel = RS_ID;
        end
      endcase
    end
  end
endmodule

// File: rtl/vic_src_regs.sv
module vic_src_regs #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en_set,
  input  logic            wr_en_clr,
  input  logic            wr_sw_set,
  input  logic            wr_sw_clr,
  input  logic            wr_route,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] route_q,
  output logic [NSRC-1:0] soft_q,
  output logic [NSRC-1:0] irq_stat,
  output logic [NSRC-1:0] fiq_stat
);
  logic [NSRC-1:0] line_q;
  logic [NSRC-1:0] req;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= '0;
      en_q    <= '0;
      route_q <= '0;
      soft_q  <= '0;
    end else begin
      line_q <= src_i;
      if (wr_en_set)      en_q <= en_q | wdata;
      else if (wr_en_clr) en_q <= en_q & ~wdata;
      if (wr_sw_set)      soft_q <= soft_q | wdata;
      else if (wr_sw_clr) soft_q <= soft_q & ~wdata;
      if (wr_route)       route_q <= wdata;
    end
  end

  assign req      = (line_q | soft_q) & en_q;
  assign irq_stat = req & ~route_q;
  assign fiq_stat = req & route_q;
endmodule

// File: rtl/vic_vec_unit.sv
module vic_vec_unit
  import vic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  parameter int SLW   = $clog2(NSLOT),
  parameter int SRCW  = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  irq_stat,
  input  logic             wr_vaddr,
  input  logic             wr_vctl,
  input  logic             wr_def,
  input  logic [SLW-1:0]   slot_idx,
  input  logic [DW-1:0]    wdata,
  input  logic             open_lvl,
  input  logic             close_lvl,
  output logic [DW-1:0]    cur_vec,
  output logic [DW-1:0]    vaddr_rd,
  output logic [DW-1:0]    vctl_rd,
  output logic [DW-1:0]    def_q,
  output logic [NSLOT-1:0] served_q
);
  logic [DW-1:0]   vaddr_mem [NSLOT];
  logic [NSLOT-1:0] slot_en_q;
  logic [SRCW-1:0]  slot_src_q [NSLOT];
  logic [NSLOT-1:0] hit;
  logic [NSLOT-1:0] eligible;
  logic             win_any;
  logic [SLW-1:0]   win_idx;

  // Handler address table: no reset, single write port
  always_ff @(posedge clk) begin
    if (wr_vaddr) vaddr_mem[slot_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_en_q <= '0;
      def_q     <= '0;
      for (int n = 0; n < NSLOT; n++) slot_src_q[n] <= '0;
    end else begin
      if (wr_vctl) begin
        slot_en_q[slot_idx]  <= wdata[CTL_EN_BIT];
        slot_src_q[slot_idx] <= wdata[SRCW-1:0];
      end
      if (wr_def) def_q <= wdata;
    end
  end

  for (genvar n = 0; n < NSLOT; n++) begin : g_slot
    assign hit[n] = slot_en_q[n] && irq_stat[slot_src_q[n]];
  end

  // A slot is skipped when it or any more urgent slot holds an open level
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int n = 0; n < NSLOT; n++) begin
      acc         = acc | served_q[n];
      eligible[n] = hit[n] & ~acc;
    end
  end

  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    for (int n = NSLOT - 1; n >= 0; n--) begin
      if (eligible[n]) begin
        win_any = 1'b1;
        win_idx = SLW'(n);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      served_q <= '0;
    end else if (open_lvl && win_any) begin
      served_q[win_idx] <= 1'b1;
    end else if (close_lvl) begin
      served_q <= served_q & (served_q - 1'b1);
    end
  end

  assign cur_vec  = win_any ? vaddr_mem[win_idx] : def_q;
  assign vaddr_rd = vaddr_mem[slot_idx];

  always_comb begin
    vctl_rd                 = '0;
    vctl_rd[CTL_EN_BIT]     = slot_en_q[slot_idx];
    vctl_rd[SRCW-1:0]       = slot_src_q[slot_idx];
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int          NSRC    = 32,
  parameter int          NSLOT   = 16,
  parameter int          DW      = 32,
  parameter logic [31:0] ID_CODE = 32'h0024_A0C3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [11:0]     paddr,
  input  logic [DW-1:0]   pwdata,
  input  logic            pprot_priv,
  output logic [DW-1:0]   prdata,
  input  logic [NSRC-1:0] src_i,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int SLW = $clog2(NSLOT);

  logic             wr_ok, rd_ok, prot_q;
  reg_sel_e         rsel;
  logic [SLW-1:0]   slot_idx;
  logic [1:0]       id_idx;
  logic [NSRC-1:0]  en_q, route_q, soft_q, irq_stat, fiq_stat;
  logic [DW-1:0]    cur_vec, vaddr_rd, vctl_rd, def_q;
  logic [NSLOT-1:0] served_q;
  logic [DW-1:0]    rd_mux;

  vic_bus_dec #(.NSLOT(NSLOT), .SLW(SLW)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pprot_priv(pprot_priv), .prot_q(prot_q), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .rsel(rsel), .slot_idx(slot_idx), .id_idx(id_idx)
  );

  vic_src_regs #(.NSRC(NSRC)) u_src (
    .clk(clk), .rst(rst), .src_i(src_i),
    .wr_en_set(wr_ok && rsel == RS_EN_SET),
    .wr_en_clr(wr_ok && rsel == RS_EN_CLR),
    .wr_sw_set(wr_ok && rsel == RS_SW_SET),
    .wr_sw_clr(wr_ok && rsel == RS_SW_CLR),
    .wr_route (wr_ok && rsel == RS_ROUTE),
    .wdata(pwdata[NSRC-1:0]),
    .en_q(en_q), .route_q(route_q), .soft_q(soft_q),
    .irq_stat(irq_stat), .fiq_stat(fiq_stat)
  );

  vic_vec_unit #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_vec (
    .clk(clk), .rst(rst), .irq_stat(irq_stat),
    .wr_vaddr(wr_ok && rsel == RS_VADDR),
    .wr_vctl (wr_ok && rsel == RS_VCTL),
    .wr_def  (wr_ok && rsel == RS_DEF_VEC),
    .slot_idx(slot_idx), .wdata(pwdata),
    .open_lvl (rd_ok && rsel == RS_CUR_VEC),
    .close_lvl(wr_ok && rsel == RS_CUR_VEC),
    .cur_vec(cur_vec), .vaddr_rd(vaddr_rd), .vctl_rd(vctl_rd),
    .def_q(def_q), .served_q(served_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                           prot_q <= 1'b0;
    else if (wr_ok && rsel == RS_PROT) prot_q <= pwdata[0];
  end

  always_comb begin
    rd_mux = '0;
    unique case (rsel)
      RS_IRQ_STAT: rd_mux = DW'(irq_stat);
      RS_FIQ_STAT: rd_mux = DW'(fiq_stat);
      RS_ROUTE:    rd_mux = DW'(route_q);
      RS_EN_SET:   rd_mux = DW'(en_q);
      RS_SW_SET:   rd_mux = DW'(soft_q);
      RS_PROT:     rd_mux = DW'(prot_q);
      RS_CUR_VEC:  rd_mux = cur_vec;
      RS_DEF_VEC:  rd_mux = def_q;
      RS_VADDR:    rd_mux = vaddr_rd;
      RS_VCTL:     rd_mux = vctl_rd;
      RS_ID:       rd_mux = DW'(ID_CODE[8*id_idx +: 8]);
      default:     rd_mux = '0;
    endcase
  end

  assign prdata = rd_ok ? rd_mux : '0;
  assign irq_o  = |irq_stat;
  assign fiq_o  = |fiq_stat;
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             psel,
  input logic             penable,
  input logic             pwrite,
  input logic [11:0]      paddr,
  input logic [DW-1:0]    pwdata,
  input logic             pprot_priv,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [NSRC-1:0]  en_q,
  input logic [NSRC-1:0]  route_q,
  input logic [NSRC-1:0]  soft_q,
  input logic             prot_q,
  input logic [NSLOT-1:0] served_q
);
  logic acc_ok;
  assign acc_ok = psel && penable && (!prot_q || pprot_priv);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq_o && !fiq_o && served_q == '0 && en_q == '0));

  assert_en_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && pwrite && paddr == 12'h014) |=> ((en_q & $past(pwdata[NSRC-1:0])) == '0));

  assert_irq_route_R4: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> |(en_q & ~route_q));

  assert_fiq_route_R4: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> |(en_q & route_q));

  assert_open_one_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && !pwrite && paddr == 12'h030)
      |=> ($countones(served_q) <= $countones($past(served_q)) + 1));

  assert_close_one_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && pwrite && paddr == 12'h030 && served_q != '0)
      |=> ($countones(served_q) + 1 == $countones($past(served_q))));

  assert_guard_R9: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pwrite && prot_q && !pprot_priv)
      |=> ($stable(en_q) && $stable(route_q) && $stable(soft_q) && prot_q));
endmodule

bind vec_irq_ctrl vic_chk #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pprot_priv(pprot_priv),
  .irq_o(irq_o), .fiq_o(fiq_o), .en_q(en_q), .route_q(route_q),
  .soft_q(soft_q), .prot_q(prot_q), .served_q(served_q)
);

// File: tb/vec_irq_ctrl_tb.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, pprot_priv = 1'b1;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [31:0] src_i = '0;
  logic        irq_o, fiq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [31:0] DEF_VEC = 32'h0000_DEF0;

  always #5 clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pprot_priv(pprot_priv), .prdata(prdata),
    .src_i(src_i), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic priv = 1'b1);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d; pprot_priv = priv;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pprot_priv = 1'b1;
  endtask

  // Driver: queue the expected value, then run the read transfer
  task automatic bus_rd(input logic [11:0] a, input logic [31:0] e, input string tag,
                        input logic priv = 1'b1);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a; pprot_priv = priv;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pprot_priv = 1'b1;
  endtask

  task automatic chk_bit(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, e);
    end
  endtask

  // Monitor: pops expected items while a read access phase is on the bus
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (psel && penable && !pwrite) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL scoreboard: got %h expected nothing", prdata);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (prdata !== e) begin
            fails++;
            $display("FAIL %s: got %h expected %h", t, prdata, e);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    #1;
    chk_bit(irq_o, 1'b0, "R1 irq_o");
    chk_bit(fiq_o, 1'b0, "R1 fiq_o");
    bus_rd(12'h000, 32'h0, "R1 irq status");
    bus_rd(12'h004, 32'h0, "R1 fiq status");
    bus_rd(12'h010, 32'h0, "R1 enable");
    bus_rd(12'h00C, 32'h0, "R1 route");
    bus_rd(12'h020, 32'h0, "R1 prot");

    // R10 identification bytes
    bus_rd(12'hFE0, 32'hC3, "R10 id0");
    bus_rd(12'hFE4, 32'hA0, "R10 id1");
    bus_rd(12'hFE8, 32'h24, "R10 id2 (vendor 0x4A across id1/id2)");
    bus_rd(12'hFEC, 32'h00, "R10 id3");

    // R2 enable set / clear
    bus_wr(12'h010, 32'h0000_00F0);
    bus_rd(12'h010, 32'h0000_00F0, "R2 set");
    bus_wr(12'h010, 32'h0000_000F);
    bus_rd(12'h010, 32'h0000_00FF, "R2 set keeps others");
    bus_wr(12'h014, 32'h0000_0030);
    bus_rd(12'h010, 32'h0000_00CF, "R2 clear");
    bus_wr(12'h014, 32'h0);
    bus_rd(12'h010, 32'h0000_00CF, "R2 zero clear");

    // R3 software requests
    bus_wr(12'h018, 32'h4);
    bus_rd(12'h018, 32'h4, "R3 soft readback");
    bus_rd(12'h000, 32'h4, "R3 soft status");
    chk_bit(irq_o, 1'b1, "R3 irq_o by soft");
    bus_wr(12'h01C, 32'h4);
    bus_rd(12'h000, 32'h0, "R3 soft cleared");
    chk_bit(irq_o, 1'b0, "R3 irq_o dropped");

    // R4 routing
    bus_wr(12'h00C, 32'h8);
    bus_wr(12'h018, 32'h9);
    bus_rd(12'h000, 32'h1, "R4 irq path");
    bus_rd(12'h004, 32'h8, "R4 fiq path");
    chk_bit(irq_o, 1'b1, "R4 irq_o");
    chk_bit(fiq_o, 1'b1, "R4 fiq_o");
    bus_wr(12'h01C, 32'h9);
    chk_bit(fiq_o, 1'b0, "R4 fiq_o dropped");

    // R5 single sampling register on the lines
    @(negedge clk);
    src_i = 32'h40;
    #1;
    chk_bit(irq_o, 1'b0, "R5 before edge");
    @(posedge clk);
    #1;
    chk_bit(irq_o, 1'b1, "R5 after edge");
    // line and software bit of the same source together (R3)
    bus_wr(12'h018, 32'h40);
    bus_wr(12'h01C, 32'h40);
    bus_rd(12'h000, 32'h40, "R3 line holds after soft clear");
    @(negedge clk);
    src_i = '0;
    bus_rd(12'h000, 32'h0, "R5 line released");

    // R11 test control write of zero
    bus_wr(12'h300, 32'h0);
    bus_rd(12'h010, 32'h0000_00CF, "R11 enable kept");
    bus_rd(12'h00C, 32'h8, "R11 route kept");

    // Vector table
    bus_wr(12'h104, 32'h0000_0100); bus_wr(12'h204, 32'h06);
    bus_wr(12'h108, 32'h1000_0200); bus_wr(12'h208, 32'h27);
    bus_wr(12'h10C, 32'h0000_0300); bus_wr(12'h20C, 32'h23);
    bus_wr(12'h114, 32'h0000_0500); bus_wr(12'h214, 32'h26);
    bus_wr(12'h034, DEF_VEC);
    bus_wr(12'h010, 32'hFFFF_FFFF);
    bus_rd(12'h034, DEF_VEC, "R6 default readback");
    bus_rd(12'h208, 32'h27, "R6 control readback");
    bus_rd(12'h030, DEF_VEC, "R6 nothing pending");
    bus_wr(12'h030, 32'h0);
    bus_wr(12'h018, 32'h8);
    bus_rd(12'h030, DEF_VEC, "R12 fast-routed source");
    bus_wr(12'h01C, 32'h8);
    bus_wr(12'h018, 32'h40);
    bus_rd(12'h030, 32'h0000_0500, "R12 disabled slot1 skipped, R6 slot5");
    bus_wr(12'h018, 32'h80);
    bus_rd(12'h030, 32'h1000_0200, "R7 preempt by slot2");
    bus_rd(12'h030, DEF_VEC, "R7 all masked");
    bus_wr(12'h030, 32'h0);
    bus_rd(12'h030, 32'h1000_0200, "R8 slot2 level closed");
    bus_wr(12'h030, 32'h0);
    bus_wr(12'h01C, 32'h80);
    bus_rd(12'h030, DEF_VEC, "R7 slot5 still open");
    bus_wr(12'h030, 32'h0);
    bus_rd(12'h030, 32'h0000_0500, "R8 unwound to slot5");
    bus_wr(12'h030, 32'h0);
    bus_wr(12'h030, 32'h0);
    bus_wr(12'h01C, 32'h40);
    bus_rd(12'h030, DEF_VEC, "R8 empty after unwind");

    // R9 protection
    bus_wr(12'h020, 32'h1);
    bus_wr(12'h014, 32'hFFFF_FFFF, 1'b0);
    bus_rd(12'h010, 32'h0, "R9 unprivileged read zero", 1'b0);
    bus_rd(12'h010, 32'hFFFF_FFFF, "R9 unprivileged write ignored");
    bus_wr(12'h020, 32'h0, 1'b0);
    bus_rd(12'h020, 32'h1, "R9 prot kept");
    bus_wr(12'h020, 32'h0);
    bus_rd(12'h010, 32'hFFFF_FFFF, "R9 open again", 1'b0);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule